// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects the five interrupt request lines of a small 8-bit processor core and decides which one is served. The lines are:

- a non-maskable trap line;
- three maskable restart lines, named 7.5, 6.5 and 5.5 after their priority level;
- one general-purpose line that carries no vector.

At every instruction boundary the core raises `boundary` for one cycle. The block answers on the following clock edge:

- If a vectored source wins, `irq_take` pulses and `irq_vec` carries the 16-bit restart address.
- If the general line wins, `inta_n` is driven low for one cycle instead, so that the requesting device can supply its own response.
- If no source is eligible, neither output responds.

The maskable sources are gated in two ways. A three-bit mask register blocks each restart line on its own. A global enable bit gates every maskable source. The enable is set and cleared by the core through pulse inputs, and it drops by itself whenever any interrupt is accepted.

The trap line ignores both the mask and the enable. It is served only after a rising edge on the line, and only while the line is still high at the boundary. Each edge is served at most once.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sets `irq_take`=0, `irq_vec`=0, `inta_n`=1 and `ien_o`=0 on the next edge. It also clears the mask bits and the trap edge latch. Reset takes priority over `ien_set`.
- R2: The trap line is recognised only after a clock edge has sampled it low and then high, and only while it is still high at the boundary. A rise in the same cycle as `boundary` is not served in that cycle. A line that has fallen by the boundary is not served.
- R3: An accepted trap gives `irq_take`=1 with `irq_vec`=16'h0024. This holds whatever the values of the mask bits and the global enable.
- R4: An accepted trap clears its edge latch. A trap line held high through later boundaries is not served again until it has gone low and risen once more.
- R5: The restart lines are active-high and level-sensitive. When one is accepted the vector is 16'h003C for 7.5, 16'h0034 for 6.5 and 16'h002C for 5.5.
- R6: The fixed priority, from highest to lowest, is trap, 7.5, 6.5, 5.5, general. Only the highest eligible source is served at a boundary.
- R7: A write with `mask_we`=1 loads `mask_wdata`. Bit 2 masks 7.5, bit 1 masks 6.5 and bit 0 masks 5.5, and a 1 blocks that line. A blocked line is never served, and a lower eligible line is served in its place.
- R8: While `ien_o`=0, none of the restart lines or the general line is served.
- R9: Acceptance of the general line drives `inta_n` low for exactly one cycle, with `irq_take`=0 and `irq_vec`=0. The general line is gated only by the global enable, not by the mask bits.
- R10: Any acceptance clears `ien_o` on the same edge, and this overrides `ien_set`. Otherwise `ien_clr` clears `ien_o` and overrides `ien_set`, and `ien_set` alone sets it. An `ien_set` in a boundary cycle does not enable that boundary.
- R11: The response appears on the clock edge that samples `boundary` high. In any cycle not following a boundary, `irq_take`=0, `irq_vec`=0 and `inta_n`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_req | input | 1 | Non-maskable trap request (edge plus level) |
| rst75_req | input | 1 | Restart request, level 7.5 |
| rst65_req | input | 1 | Restart request, level 6.5 |
| rst55_req | input | 1 | Restart request, level 5.5 |
| gen_req | input | 1 | General non-vectored request |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 3 | Mask data: bit 2 = 7.5, bit 1 = 6.5, bit 0 = 5.5, 1 blocks |
| ien_set | input | 1 | Pulse that sets the global enable |
| ien_clr | input | 1 | Pulse that clears the global enable |
| boundary | input | 1 | Core is at an instruction boundary |
| irq_take | output | 1 | One-cycle pulse: a vectored interrupt was accepted |
| irq_vec | output | 16 | Restart address, valid with `irq_take`, zero otherwise |
| inta_n | output | 1 | Active-low acknowledge for the general request |
| ien_o | output | 1 | Current global enable bit |

## Verification
Several patterns are applied:

- **All maskable lines high at once.** The lines are then dropped one by one, which shows whether the priority chain and each restart vector are right.
- **Partial and full masks.** Applied with the higher lines still asserted, these separate mask gating from enable gating, and show that the general line bypasses the mask.
- **Trap timing.** The trap is raised in the same cycle as a boundary, dropped just before one, held high across two boundaries, and raised alongside 7.5. This tells the edge latch apart from a level decode and from a plain edge detector.
- **Enable races.** Set and clear pulses are placed in the same cycle as each other and as an acceptance, which pins down the override order of the enable bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int VEC_W   = 16;
    localparam int NUM_RST = 3;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_GEN  = 3'd5
    } src_t;

    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             ack_n;
    } resp_t;

    localparam resp_t RESP_IDLE = '{take: 1'b0, vec: '0, ack_n: 1'b1};

    function automatic logic [VEC_W-1:0] vec_of(input src_t s);
        case (s)
            SRC_TRAP: vec_of = VEC_TRAP;
            SRC_R75:  vec_of = VEC_R75;
            SRC_R65:  vec_of = VEC_R65;
            SRC_R55:  vec_of = VEC_R55;
            default:  vec_of = '0;
        endcase
    endfunction

    function automatic src_t rst_src(input int idx);
        case (idx)
            2:       rst_src = SRC_R75;
            1:       rst_src = SRC_R65;
            default: rst_src = SRC_R55;
        endcase
    endfunction

endpackage

// File: rtl/irqc_trap_latch.sv
module irqc_trap_latch (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic accept,
    output logic valid
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req;
            if (req && !prev_q)
                pend_q <= 1'b1;
            else if (accept || !req)
                pend_q <= 1'b0;
        end
    end

    assign valid = pend_q && req;

    AST_TRAP_ONCE: assert property (@(posedge clk) disable iff (rst)
        accept |=> !pend_q); // R4
    AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> $past(req)); // R2

endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs #(
    parameter int NRST = irqc_pkg::NUM_RST
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mask_we,
    input  logic [NRST-1:0] mask_wdata,
    input  logic            ien_set,
    input  logic            ien_clr,
    input  logic            accept,
    output logic [NRST-1:0] mask_q,
    output logic            ien_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (mask_we)
                mask_q <= mask_wdata;
            if (accept || ien_clr)
                ien_q <= 1'b0;
            else if (ien_set)
                ien_q <= 1'b1;
        end
    end

    AST_IEN_SET: assert property (@(posedge clk) disable iff (rst)
        (ien_set && !ien_clr && !accept) |=> ien_q); // R10
    AST_IEN_ACCEPT_CLR: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ien_q); // R10

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NRST = NUM_RST
) (
    input  logic            trap_ok,
    input  logic [NRST-1:0] rst_req,
    input  logic [NRST-1:0] mask,
    input  logic            gen_req,
    input  logic            ien,
    output src_t            win
);
    logic [NRST-1:0] rst_ok;

    genvar g;
    generate
        for (g = 0; g < NRST; g++) begin : g_lane
            assign rst_ok[g] = rst_req[g] && !mask[g] && ien;
        end
    endgenerate

    always_comb begin
        win = SRC_NONE;
        if (gen_req && ien)
            win = SRC_GEN;
        for (int i = 0; i < NRST; i++) begin
            if (rst_ok[i])
                win = rst_src(i);
        end
        if (trap_ok)
            win = SRC_TRAP;
    end

    always_comb begin
        if (win == SRC_GEN)
            AST_GEN_LOWEST: assert (!trap_ok && rst_ok == '0); // R6
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        trap_req,
    input  logic        rst75_req,
    input  logic        rst65_req,
    input  logic        rst55_req,
    input  logic        gen_req,
    input  logic        mask_we,
    input  logic [2:0]  mask_wdata,
    input  logic        ien_set,
    input  logic        ien_clr,
    input  logic        boundary,
    output logic        irq_take,
    output logic [15:0] irq_vec,
    output logic        inta_n,
    output logic        ien_o
);
    logic                trap_ok;
    logic                accept;
    logic                trap_acc;
    logic [NUM_RST-1:0]  mask_q;
    logic [NUM_RST-1:0]  rst_lines;
    src_t                win;
    resp_t               resp_d;
    resp_t               resp_q;

    assign rst_lines = {rst75_req, rst65_req, rst55_req};
    assign accept    = boundary && (win != SRC_NONE);
    assign trap_acc  = boundary && (win == SRC_TRAP);

    irqc_trap_latch i_trap (
        .clk    (clk),
        .rst    (rst),
        .req    (trap_req),
        .accept (trap_acc),
        .valid  (trap_ok)
    );

    irqc_ctrl_regs #(.NRST(NUM_RST)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .ien_set    (ien_set),
        .ien_clr    (ien_clr),
        .accept     (accept),
        .mask_q     (mask_q),
        .ien_q      (ien_o)
    );

    irqc_arbiter #(.NRST(NUM_RST)) i_arb (
        .trap_ok (trap_ok),
        .rst_req (rst_lines),
        .mask    (mask_q),
        .gen_req (gen_req),
        .ien     (ien_o),
        .win     (win)
    );

    always_comb begin
        resp_d = RESP_IDLE;
        if (boundary) begin
            if (win == SRC_GEN) begin
                resp_d.ack_n = 1'b0;
            end else if (win != SRC_NONE) begin
                resp_d.take = 1'b1;
                resp_d.vec  = vec_of(win);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            resp_q <= RESP_IDLE;
        else
            resp_q <= resp_d;
    end

    assign irq_take = resp_q.take;
    assign irq_vec  = resp_q.vec;
    assign inta_n   = resp_q.ack_n;

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        !(irq_take && !inta_n)); // R9
    AST_RESP_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (irq_take || !inta_n) |-> $past(boundary)); // R11
    AST_IEN_DROPS: assert property (@(posedge clk) disable iff (rst)
        (irq_take || !inta_n) |-> !ien_o); // R10
    AST_MASK_HONOURED: assert property (@(posedge clk) disable iff (rst)
        (irq_take && irq_vec == VEC_R75) |-> !$past(mask_q[2])); // R7

endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_req = 1'b0, rst75_req = 1'b0, rst65_req = 1'b0, rst55_req = 1'b0;
    logic        gen_req = 1'b0, mask_we = 1'b0, ien_set = 1'b0, ien_clr = 1'b0;
    logic        boundary = 1'b0;
    logic [2:0]  mask_wdata = 3'b000;
    logic        irq_take, inta_n, ien_o;
    logic [15:0] irq_vec;

    localparam logic [15:0] E_TRAP = 16'h0024;
    localparam logic [15:0] E_75   = 16'h003C;
    localparam logic [15:0] E_65   = 16'h0034;
    localparam logic [15:0] E_55   = 16'h002C;

    typedef struct packed {
        logic        take;
        logic [15:0] vec;
        logic        ack_n;
        logic        ien;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    due_q[$];
    int    cyc = 0;
    int    nchk = 0;
    int    nbad = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst(rst), .trap_req(trap_req), .rst75_req(rst75_req),
        .rst65_req(rst65_req), .rst55_req(rst55_req), .gen_req(gen_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ien_set(ien_set),
        .ien_clr(ien_clr), .boundary(boundary), .irq_take(irq_take),
        .irq_vec(irq_vec), .inta_n(inta_n), .ien_o(ien_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the expected item that falls due after this edge
    always @(negedge clk) begin
        if (due_q.size() > 0 && due_q[0] == cyc) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            void'(due_q.pop_front());
            nchk++;
            if (irq_take !== e.take || irq_vec !== e.vec ||
                inta_n !== e.ack_n || ien_o !== e.ien) begin
                nbad++;
                $display("FAIL %s: got take=%0b vec=%h ack_n=%0b ien=%0b, expected take=%0b vec=%h ack_n=%0b ien=%0b",
                         t, irq_take, irq_vec, inta_n, ien_o, e.take, e.vec, e.ack_n, e.ien);
            end
        end
    end

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic bnd, input logic et, input logic [15:0] ev,
                        input logic ea, input logic ei, input string tag);
        exp_t e;
        boundary = bnd;
        e = '{take: et, vec: ev, ack_n: ea, ien: ei};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        due_q.push_back(cyc + 1);
        @(negedge clk);
        ien_set = 1'b0;
        ien_clr = 1'b0;
        mask_we = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        ien_set = 1'b1;
        step(0, 0, 16'h0, 1, 0, "R1");
        rst = 1'b0;

        rst75_req = 1'b1; gen_req = 1'b1;
        step(1, 0, 16'h0, 1, 0, "R8");
        ien_set = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R10");
        rst65_req = 1'b1; rst55_req = 1'b1;
        step(1, 1, E_75, 1, 0, "R6");
        step(0, 0, 16'h0, 1, 0, "R11");

        rst75_req = 1'b0; ien_set = 1'b1;
        step(1, 0, 16'h0, 1, 1, "R10");
        step(1, 1, E_65, 1, 0, "R5");
        rst65_req = 1'b0; ien_set = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R10");
        step(1, 1, E_55, 1, 0, "R5");
        rst55_req = 1'b0; ien_set = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R10");
        step(1, 0, 16'h0, 0, 0, "R9");
        gen_req = 1'b0;
        step(0, 0, 16'h0, 1, 0, "R9");

        mask_we = 1'b1; mask_wdata = 3'b100; ien_set = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R7");
        rst75_req = 1'b1; rst65_req = 1'b1;
        step(1, 1, E_65, 1, 0, "R7");
        mask_we = 1'b1; mask_wdata = 3'b111; ien_set = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R7");
        rst55_req = 1'b1;
        step(1, 0, 16'h0, 1, 1, "R7");
        gen_req = 1'b1;
        step(1, 0, 16'h0, 0, 0, "R9");
        gen_req = 1'b0; rst75_req = 1'b0; rst65_req = 1'b0; rst55_req = 1'b0;

        trap_req = 1'b1;
        step(0, 0, 16'h0, 1, 0, "R2");
        step(1, 1, E_TRAP, 1, 0, "R3");
        step(1, 0, 16'h0, 1, 0, "R4");
        trap_req = 1'b0;
        step(0, 0, 16'h0, 1, 0, "R4");
        trap_req = 1'b1;
        step(1, 0, 16'h0, 1, 0, "R2");
        trap_req = 1'b0;
        step(1, 0, 16'h0, 1, 0, "R2");
        trap_req = 1'b1;
        step(0, 0, 16'h0, 1, 0, "R2");
        step(0, 0, 16'h0, 1, 0, "R2");
        step(1, 1, E_TRAP, 1, 0, "R3");

        trap_req = 1'b0; mask_we = 1'b1; mask_wdata = 3'b000; ien_set = 1'b1; rst75_req = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R7");
        trap_req = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R2");
        step(1, 1, E_TRAP, 1, 0, "R6");
        trap_req = 1'b0; ien_set = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R10");
        step(1, 1, E_75, 1, 0, "R5");

        ien_set = 1'b1; ien_clr = 1'b1;
        step(0, 0, 16'h0, 1, 0, "R10");
        ien_set = 1'b1;
        step(0, 0, 16'h0, 1, 1, "R10");
        ien_set = 1'b1;
        step(1, 1, E_75, 1, 0, "R10");
        rst75_req = 1'b0;
        step(0, 0, 16'h0, 1, 0, "R11");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

endmodule